// File: doc/BRIEF.md
# Dispatch Stall and Skid Controller

This block sits between the rename stage and the issue queues of an out-of-order core. It handles dispatch for one thread. Each cycle it accepts a packed group of up to `W` instruction records from rename. Each record is a tag plus a memory-access bit and a cancelled bit. It forwards up to `W` of them per cycle to the instruction queue and to the load/store queue. The block raises a one-cycle hold request to rename when it must stop accepting, and a one-cycle release request when it has caught up again. It also reports two credit counts per cycle: how many records it retired, and how many of those were memory accesses.

While dispatch is held, incoming groups park in an internal skid store. When the hold clears, the parked records leave oldest first, ahead of anything newer. Records that arrive during the drain queue up behind the parked ones. A flush from commit, or a report that the reorder buffer is still unwinding, discards everything held or arriving. Every discarded record is credited back. All outputs are registered, so each output reflects the inputs of the previous cycle.

Top module: `dispatch_skid_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all outputs read zero, the skid store is empty, the commit hold flag is clear, and the next group is dispatched without any hold.
- R2: With no hold in effect, the first `in_cnt` lanes (capped at `W`) appear in the next cycle on `iq_valid`/`iq_tag` in the same lane order. `disp_cnt` equals the lane count and `disp_mem_cnt` equals the number of those lanes whose memory bit is set.
- R3: A record whose cancelled bit is set is not presented on `iq_valid`. It still counts in `disp_cnt`, and it counts in `disp_mem_cnt` if its memory bit is set.
- R4: Any of the commit hold flag, `iq_full`, `lsq_full` or `lsq_stall` stops dispatch, and the arriving group is parked. `up_block` pulses only on entry from a state that was not already holding or draining.
- R5: `commit_block` sets a sticky commit hold flag and `commit_unblock` clears it. When both arrive in the same cycle, the flag ends clear and that cycle is not held.
- R6: Once no hold remains, parked records drain at up to `W` per cycle, oldest first, and new arrivals are parked behind them. `up_unblock` pulses in the cycle the store becomes empty with no arrival, and normal dispatch resumes.
- R7: If more than `W` records remain parked, a drain cycle dispatches `W` of them and keeps holding, with `up_unblock` low.
- R8: `commit_squash` flushes the store and the arriving group and dispatches nothing. `disp_cnt`/`disp_mem_cnt` return the flushed totals. `up_unblock` pulses if the block was holding or draining. The following cycle dispatches normally.
- R9: `rob_squashing` flushes and credits in the same way as R8 but never raises `up_unblock`.
- R10: The store depth is 3 × (rename delay × rename width) + `W`. A push that would exceed it sets `skid_ovf`, which stays set until reset.
- R11: Priority each cycle is `commit_squash`, then `rob_squashing`, then the hold causes, then drain or normal dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_cnt | input | $clog2(W+1) | Number of valid lanes in the arriving group (packed from lane 0) |
| in_tag | input | W*TAG_W | Per-lane instruction tags |
| in_mem | input | W | Per-lane memory-access bit |
| in_sq | input | W | Per-lane cancelled bit |
| commit_block | input | 1 | Sets the sticky commit hold flag |
| commit_unblock | input | 1 | Clears the sticky commit hold flag |
| commit_squash | input | 1 | Flush request from commit |
| rob_squashing | input | 1 | Reorder buffer still unwinding |
| iq_full | input | 1 | Instruction queue full |
| lsq_full | input | 1 | Load/store queue full |
| lsq_stall | input | 1 | Load/store queue stalled |
| iq_valid | output | W | Lanes inserted into the queues this cycle |
| iq_tag | output | W*TAG_W | Tags of the inserted lanes |
| iq_mem | output | W | Inserted lanes that also enter the load/store queue |
| disp_cnt | output | $clog2(DEPTH+W+1) | Records retired (dispatched, dropped or flushed) |
| disp_mem_cnt | output | $clog2(DEPTH+W+1) | Memory records among those retired |
| up_block | output | 1 | Hold request pulse to rename |
| up_unblock | output | 1 | Release request pulse to rename |
| skid_ovf | output | 1 | Sticky skid store overflow error |

## Verification
A state machine stuck in holding mode shows up one cycle later: valid groups arrive and `iq_valid` stays zero. A lost parked record shows as a gap in the tag sequence of the drain, or as a credit total that comes up short after a flush. A wrong drain length moves the `up_unblock` pulse to an earlier or later cycle. Because every output is one register away from its cause, each of these faults appears on the very next cycle. The bench steps one cycle per vector, so each fault is pinned to the vector that caused it.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    ST_RUNNING    = 3'd0,
    ST_IDLE       = 3'd1,
    ST_BLOCKED    = 3'd2,
    ST_UNBLOCKING = 3'd3,
    ST_SQUASHING  = 3'd4
  } disp_state_e;

  // Record layout inside the skid store: {tag, mem, cancelled}
  localparam int E_SQ  = 0;
  localparam int E_MEM = 1;
endpackage

// File: rtl/dsc_stall_track.sv
module dsc_stall_track (
  input  logic clk,
  input  logic rst,
  input  logic commit_block,
  input  logic commit_unblock,
  input  logic iq_full,
  input  logic lsq_full,
  input  logic lsq_stall,
  output logic stall
);
  logic flag_q, flag_d;

  // set first, then clear: a same-cycle pair leaves the flag clear
  always_comb begin
    flag_d = (flag_q | commit_block) & ~commit_unblock;
    stall  = flag_d | iq_full | lsq_full | lsq_stall;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end
endmodule

// File: rtl/dsc_skid_fifo.sv
module dsc_skid_fifo #(
  parameter int W       = 4,
  parameter int EW      = 10,
  parameter int DEPTH   = 16,
  parameter int MEM_BIT = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flush,
  input  logic [$clog2(W+1)-1:0]    push_n,
  input  logic [W*EW-1:0]           push_data,
  input  logic [$clog2(W+1)-1:0]    pop_n,
  output logic [W*EW-1:0]           head_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [$clog2(DEPTH+1)-1:0] mem_count,
  output logic                      ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [EW-1:0] slot_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q, memc_q;
  int            push_eff, push_mem, pop_mem;

  function automatic logic [PW-1:0] wrap(input logic [PW-1:0] p, input int off);
    int s;
    s = int'(p) + off;
    if (s >= DEPTH) s -= DEPTH;
    return PW'(s);
  endfunction

  generate
    for (genvar i = 0; i < W; i++) begin : g_head
      assign head_data[i*EW +: EW] = slot_q[wrap(rd_q, i)];
    end
  endgenerate

  always_comb begin
    int space;
    space    = DEPTH - int'(cnt_q) + int'(pop_n);
    ovf      = int'(push_n) > space;
    push_eff = ovf ? space : int'(push_n);
    push_mem = 0;
    pop_mem  = 0;
    for (int i = 0; i < W; i++) begin
      if (i < push_eff)     push_mem += int'(push_data[i*EW + MEM_BIT]);
      if (i < int'(pop_n))  pop_mem  += int'(head_data[i*EW + MEM_BIT]);
    end
  end

  // storage has no reset so it can map onto plain memory bits
  always_ff @(posedge clk) begin
    for (int i = 0; i < W; i++)
      if (!flush && i < push_eff) slot_q[wrap(wr_q, i)] <= push_data[i*EW +: EW];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      memc_q <= '0;
    end else begin
      wr_q   <= wrap(wr_q, push_eff);
      rd_q   <= wrap(rd_q, int'(pop_n));
      cnt_q  <= CW'(int'(cnt_q) + push_eff - int'(pop_n));
      memc_q <= CW'(int'(memc_q) + push_mem - pop_mem);
    end
  end

  assign count     = cnt_q;
  assign mem_count = memc_q;
endmodule

// File: rtl/dispatch_skid_ctrl.sv
module dispatch_skid_ctrl #(
  parameter int W       = 4,
  parameter int TAG_W   = 8,
  parameter int REN_W   = 4,
  parameter int REN_DLY = 1,
  localparam int DEPTH  = 3 * (REN_DLY * REN_W) + W,
  localparam int OW     = $clog2(DEPTH + W + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [$clog2(W+1)-1:0] in_cnt,
  input  logic [W*TAG_W-1:0]     in_tag,
  input  logic [W-1:0]           in_mem,
  input  logic [W-1:0]           in_sq,
  input  logic                   commit_block,
  input  logic                   commit_unblock,
  input  logic                   commit_squash,
  input  logic                   rob_squashing,
  input  logic                   iq_full,
  input  logic                   lsq_full,
  input  logic                   lsq_stall,
  output logic [W-1:0]           iq_valid,
  output logic [W*TAG_W-1:0]     iq_tag,
  output logic [W-1:0]           iq_mem,
  output logic [OW-1:0]          disp_cnt,
  output logic [OW-1:0]          disp_mem_cnt,
  output logic                   up_block,
  output logic                   up_unblock,
  output logic                   skid_ovf
);
  import dsc_pkg::*;

  localparam int NW = $clog2(W + 1);
  localparam int EW = TAG_W + 2;
  localparam int CW = $clog2(DEPTH + 1);

  disp_state_e      st_q, st_d;
  logic [NW-1:0]    in_n, push_n, pop_n, take_n;
  logic [W-1:0]     lane_mask;
  logic [W*EW-1:0]  in_flat, hd_flat;
  logic [CW-1:0]    sk_cnt, sk_mem;
  logic             fifo_ovf, stall, flush, from_skid, was_blk;
  logic             blk_d, unb_d;
  logic [OW-1:0]    fl_cnt, fl_mem, dcnt_d, mcnt_d;
  logic [W-1:0]     v_d, m_d;
  logic [W*TAG_W-1:0] t_d;
  int               in_mem_n, lane_mem_n;

  assign in_n = (int'(in_cnt) > W) ? NW'(W) : in_cnt;

  generate
    for (genvar i = 0; i < W; i++) begin : g_in
      assign lane_mask[i] = (i < int'(in_n));
      assign in_flat[i*EW +: EW] = {in_tag[i*TAG_W +: TAG_W], in_mem[i], in_sq[i]};
    end
  endgenerate

  assign in_mem_n = $countones(in_mem & lane_mask);

  dsc_stall_track u_stall (
    .clk(clk), .rst(rst),
    .commit_block(commit_block), .commit_unblock(commit_unblock),
    .iq_full(iq_full), .lsq_full(lsq_full), .lsq_stall(lsq_stall),
    .stall(stall)
  );

  dsc_skid_fifo #(.W(W), .EW(EW), .DEPTH(DEPTH), .MEM_BIT(E_MEM)) u_skid (
    .clk(clk), .rst(rst), .flush(flush),
    .push_n(push_n), .push_data(in_flat),
    .pop_n(pop_n), .head_data(hd_flat),
    .count(sk_cnt), .mem_count(sk_mem), .ovf(fifo_ovf)
  );

  // next-state decision, in priority order
  always_comb begin
    st_d      = st_q;
    flush     = 1'b0;
    from_skid = 1'b0;
    blk_d     = 1'b0;
    unb_d     = 1'b0;
    push_n    = '0;
    pop_n     = '0;
    take_n    = '0;
    fl_cnt    = OW'(int'(sk_cnt) + int'(in_n));
    fl_mem    = OW'(int'(sk_mem) + in_mem_n);
    was_blk   = (st_q == ST_BLOCKED) || (st_q == ST_UNBLOCKING);
    if (commit_squash || rob_squashing) begin
      flush = 1'b1;
      unb_d = commit_squash && was_blk;
      st_d  = ST_SQUASHING;
    end else if (stall) begin
      push_n = in_n;
      blk_d  = !was_blk;
      st_d   = ST_BLOCKED;
    end else if (was_blk) begin
      from_skid = 1'b1;
      take_n    = (int'(sk_cnt) > W) ? NW'(W) : NW'(sk_cnt);
      pop_n     = take_n;
      push_n    = in_n;
      if (int'(sk_cnt) > W)  st_d = ST_BLOCKED;
      else if (in_n != '0)   st_d = ST_UNBLOCKING;
      else begin
        st_d  = ST_RUNNING;
        unb_d = 1'b1;
      end
    end else begin
      take_n = in_n;
      st_d   = ST_RUNNING;
    end
  end

  // lane selection: skid heads while draining, else the arriving group
  always_comb begin
    logic [EW-1:0] ent;
    v_d        = '0;
    m_d        = '0;
    t_d        = '0;
    lane_mem_n = 0;
    for (int i = 0; i < W; i++) begin
      ent = from_skid ? hd_flat[i*EW +: EW] : in_flat[i*EW +: EW];
      if (i < int'(take_n)) begin
        v_d[i]              = !ent[E_SQ];
        m_d[i]              = ent[E_MEM] && !ent[E_SQ];
        t_d[i*TAG_W +: TAG_W] = ent[EW-1:2];
        lane_mem_n         += int'(ent[E_MEM]);
      end
    end
    dcnt_d = flush ? fl_cnt : OW'(take_n);
    mcnt_d = flush ? fl_mem : OW'(lane_mem_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_RUNNING;
      iq_valid     <= '0;
      iq_tag       <= '0;
      iq_mem       <= '0;
      disp_cnt     <= '0;
      disp_mem_cnt <= '0;
      up_block     <= 1'b0;
      up_unblock   <= 1'b0;
      skid_ovf     <= 1'b0;
    end else begin
      st_q         <= st_d;
      iq_valid     <= v_d;
      iq_tag       <= t_d;
      iq_mem       <= m_d;
      disp_cnt     <= dcnt_d;
      disp_mem_cnt <= mcnt_d;
      up_block     <= blk_d;
      up_unblock   <= unb_d;
      skid_ovf     <= skid_ovf | fifo_ovf;
    end
  end
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int W       = 4,
  parameter int TAG_W   = 8,
  parameter int REN_W   = 4,
  parameter int REN_DLY = 1,
  localparam int DEPTH  = 3 * (REN_DLY * REN_W) + W,
  localparam int OW     = $clog2(DEPTH + W + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          commit_block,
  input logic          commit_unblock,
  input logic          commit_squash,
  input logic          rob_squashing,
  input logic          iq_full,
  input logic          lsq_full,
  input logic          lsq_stall,
  input logic [W-1:0]  iq_valid,
  input logic [OW-1:0] disp_cnt,
  input logic [OW-1:0] disp_mem_cnt,
  input logic          up_block,
  input logic          up_unblock,
  input logic          skid_ovf
);
  p_pulse_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(up_block && up_unblock));

  p_block_once_r4: assert property (@(posedge clk) disable iff (rst)
    up_block |=> !up_block);

  p_hold_stops_r4: assert property (@(posedge clk) disable iff (rst)
    ((iq_full || lsq_full || lsq_stall || (commit_block && !commit_unblock))
      && !commit_squash && !rob_squashing) |=> (iq_valid == '0 && disp_cnt == '0));

  p_flush_no_insert_r8: assert property (@(posedge clk) disable iff (rst)
    (commit_squash || rob_squashing) |=> (iq_valid == '0 && !up_block));

  p_rate_limit_r2: assert property (@(posedge clk) disable iff (rst)
    !(commit_squash || rob_squashing) |=> (int'(disp_cnt) <= W));

  p_mem_within_r3: assert property (@(posedge clk) disable iff (rst)
    disp_mem_cnt <= disp_cnt);

  p_rob_no_release_r9: assert property (@(posedge clk) disable iff (rst)
    (rob_squashing && !commit_squash) |=> !up_unblock);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    skid_ovf |=> skid_ovf);
endmodule

bind dispatch_skid_ctrl dsc_checker #(.W(W), .TAG_W(TAG_W), .REN_W(REN_W), .REN_DLY(REN_DLY)) u_chk (
  .clk(clk), .rst(rst),
  .commit_block(commit_block), .commit_unblock(commit_unblock),
  .commit_squash(commit_squash), .rob_squashing(rob_squashing),
  .iq_full(iq_full), .lsq_full(lsq_full), .lsq_stall(lsq_stall),
  .iq_valid(iq_valid), .disp_cnt(disp_cnt), .disp_mem_cnt(disp_mem_cnt),
  .up_block(up_block), .up_unblock(up_unblock), .skid_ovf(skid_ovf)
);

// File: tb/dispatch_skid_ctrl_tb_top.sv
`timescale 1ns/1ps
module dispatch_skid_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  in_cnt = '0;
  logic [31:0] in_tag = '0;
  logic [3:0]  in_mem = '0, in_sq = '0;
  logic        commit_block = 0, commit_unblock = 0, commit_squash = 0, rob_squashing = 0;
  logic        iq_full = 0, lsq_full = 0, lsq_stall = 0;
  logic [3:0]  iq_valid, iq_mem;
  logic [31:0] iq_tag;
  logic [4:0]  disp_cnt, disp_mem_cnt;
  logic        up_block, up_unblock, skid_ovf;

  int nvec = 0, nfail = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  dispatch_skid_ctrl dut_i (
    .clk(clk), .rst(rst), .in_cnt(in_cnt), .in_tag(in_tag), .in_mem(in_mem), .in_sq(in_sq),
    .commit_block(commit_block), .commit_unblock(commit_unblock),
    .commit_squash(commit_squash), .rob_squashing(rob_squashing),
    .iq_full(iq_full), .lsq_full(lsq_full), .lsq_stall(lsq_stall),
    .iq_valid(iq_valid), .iq_tag(iq_tag), .iq_mem(iq_mem),
    .disp_cnt(disp_cnt), .disp_mem_cnt(disp_mem_cnt),
    .up_block(up_block), .up_unblock(up_unblock), .skid_ovf(skid_ovf)
  );

  // ctl bits: {cb, cu, csq, rob, iqf, lsqf, lsqs}
  typedef struct packed {
    logic [2:0] cnt; logic [7:0] tag; logic [3:0] mem; logic [3:0] sq; logic [6:0] ctl;
    logic [3:0] ev;  logic [7:0] et;  logic [4:0] ed;  logic [4:0] em; logic eb; logic eu;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [22] = '{
    '{3'd4, 8'h10, 4'b0011, 4'b0000, 7'b0000000, 4'b1111, 8'h10, 5'd4, 5'd2, 1'b0, 1'b0, 4'd2},  // R2
    '{3'd3, 8'h20, 4'b0100, 4'b0010, 7'b0000000, 4'b0101, 8'h20, 5'd3, 5'd1, 1'b0, 1'b0, 4'd3},  // R3
    '{3'd0, 8'h00, 4'b0000, 4'b0000, 7'b0000000, 4'b0000, 8'h00, 5'd0, 5'd0, 1'b0, 1'b0, 4'd2},  // R2
    '{3'd4, 8'h30, 4'b1000, 4'b0000, 7'b0000100, 4'b0000, 8'h00, 5'd0, 5'd0, 1'b1, 1'b0, 4'd4},  // R4
    '{3'd4, 8'h34, 4'b0001, 4'b0000, 7'b0000100, 4'b0000, 8'h00, 5'd0, 5'd0, 1'b0, 1'b0, 4'd4},  // R4
    '{3'd0, 8'h00, 4'b0000, 4'b0000, 7'b0000000, 4'b1111, 8'h30, 5'd4, 5'd1, 1'b0, 1'b0, 4'd7},  // R7
    '{3'd2, 8'h38, 4'b0000, 4'b0000, 7'b0000000, 4'b1111, 8'h34, 5'd4, 5'd1, 1'b0, 1'b0, 4'd6},  // R6
    '{3'd0, 8'h00, 4'b0000, 4'b0000, 7'b0000000, 4'b0011, 8'h38, 5'd2, 5'd0, 1'b0, 1'b1, 4'd6},  // R6
    '{3'd1, 8'h40, 4'b0000, 4'b0000, 7'b0000000, 4'b0001, 8'h40, 5'd1, 5'd0, 1'b0, 1'b0, 4'd2},  // R2
    '{3'd2, 8'h50, 4'b0011, 4'b0000, 7'b1000000, 4'b0000, 8'h00, 5'd0, 5'd0, 1'b1, 1'b0, 4'd5},  // R5
    '{3'd0, 8'h00, 4'b0000, 4'b0000, 7'b0000000, 4'b0000, 8'h00, 5'd0, 5'd0, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd0, 8'h00, 4'b0000, 4'b0000, 7'b0100000, 4'b0011, 8'h50, 5'd2, 5'd2, 1'b0, 1'b1, 4'd5},  // R5
    '{3'd1, 8'h58, 4'b0000, 4'b0000, 7'b1100000, 4'b0001, 8'h58, 5'd1, 5'd0, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd3, 8'h60, 4'b0111, 4'b0000, 7'b0000001, 4'b0000, 8'h00, 5'd0, 5'd0, 1'b1, 1'b0, 4'd4},  // R4
    '{3'd2, 8'h63, 4'b0001, 4'b0000, 7'b0010000, 4'b0000, 8'h00, 5'd5, 5'd4, 1'b0, 1'b1, 4'd8},  // R8
    '{3'd2, 8'h70, 4'b0000, 4'b0000, 7'b0000000, 4'b0011, 8'h70, 5'd2, 5'd0, 1'b0, 1'b0, 4'd8},  // R8
    '{3'd1, 8'h78, 4'b0001, 4'b0000, 7'b0010000, 4'b0000, 8'h00, 5'd1, 5'd1, 1'b0, 1'b0, 4'd8},  // R8
    '{3'd2, 8'h80, 4'b0000, 4'b0000, 7'b0011100, 4'b0000, 8'h00, 5'd2, 5'd0, 1'b0, 1'b0, 4'd11}, // R11
    '{3'd3, 8'h88, 4'b0010, 4'b0000, 7'b0001010, 4'b0000, 8'h00, 5'd3, 5'd1, 1'b0, 1'b0, 4'd9},  // R9
    '{3'd1, 8'h90, 4'b0000, 4'b0000, 7'b0000000, 4'b0001, 8'h90, 5'd1, 5'd0, 1'b0, 1'b0, 4'd9},  // R9
    '{3'd4, 8'hA0, 4'b0101, 4'b0000, 7'b0000010, 4'b0000, 8'h00, 5'd0, 5'd0, 1'b1, 1'b0, 4'd4},  // R4
    '{3'd0, 8'h00, 4'b0000, 4'b0000, 7'b0000000, 4'b1111, 8'hA0, 5'd4, 5'd2, 1'b0, 1'b1, 4'd6}   // R6
  };

  function automatic logic [48:0] pack_obs(input logic [3:0] v, input logic [31:0] tg,
      input logic [3:0] mask, input logic [4:0] d, input logic [4:0] m,
      input logic b, input logic u, input logic o);
    logic [31:0] mt = '0;
    for (int i = 0; i < 4; i++) if (mask[i]) mt[i*8 +: 8] = tg[i*8 +: 8];
    return {v, mt, d, m, b, u, o};
  endfunction

  task automatic apply(input logic [2:0] c, input logic [7:0] t0, input logic [3:0] mm,
                       input logic [3:0] sqm, input logic [6:0] ctl);
    in_cnt = c;
    for (int i = 0; i < 4; i++) in_tag[i*8 +: 8] = t0 + 8'(i);
    in_mem = mm;
    in_sq  = sqm;
    {commit_block, commit_unblock, commit_squash, rob_squashing, iq_full, lsq_full, lsq_stall} = ctl;
  endtask

  task automatic expect_out(input string rq, input logic [3:0] ev, input logic [7:0] et,
                            input logic [4:0] ed, input logic [4:0] em,
                            input logic eb, input logic eu, input logic eo);
    logic [31:0] etags;
    logic [48:0] act, exp;
    for (int i = 0; i < 4; i++) etags[i*8 +: 8] = et + 8'(i);
    act = pack_obs(iq_valid, iq_tag, ev, disp_cnt, disp_mem_cnt, up_block, up_unblock, skid_ovf);
    exp = pack_obs(ev, etags, ev, ed, em, eb, eu, eo);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_out("R1 reset state", 4'b0, 8'h0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0);

    for (int k = 0; k < 22; k++) begin
      apply(VEC[k].cnt, VEC[k].tag, VEC[k].mem, VEC[k].sq, VEC[k].ctl);
      @(negedge clk);
      expect_out($sformatf("R%0d vector %0d", VEC[k].req, k), VEC[k].ev, VEC[k].et,
                 VEC[k].ed, VEC[k].em, VEC[k].eb, VEC[k].eu, 1'b0);
    end

    // R10: fill the store under lsq_full, the fifth group overflows
    for (int k = 0; k < 5; k++) begin
      apply(3'd4, 8'hC0 + 8'(4*k), 4'b0000, 4'b0000, 7'b0000010);
      @(negedge clk);
      expect_out("R10 overflow fill", 4'b0, 8'h0, 5'd0, 5'd0, k == 0, 1'b0, k == 4);
    end
    // R7: drain 16 parked records at 4 per cycle, release on the last
    apply(3'd0, 8'h00, 4'b0, 4'b0, 7'b0);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      expect_out("R7 long drain", 4'b1111, 8'hC0 + 8'(4*j), 5'd4, 5'd0, 1'b0, j == 3, 1'b1);
    end

    // R1: reset mid-run clears error and state
    apply(3'd4, 8'hE0, 4'b0, 4'b0, 7'b0000100);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    apply(3'd0, 8'h00, 4'b0, 4'b0, 7'b0);
    expect_out("R1 reset clears", 4'b0, 8'h0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0);
    apply(3'd2, 8'hD0, 4'b0010, 4'b0, 7'b0);
    @(negedge clk);
    expect_out("R1 dispatch after reset", 4'b0011, 8'hD0, 5'd2, 5'd1, 1'b0, 1'b0, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule